// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This block sits at the instruction boundary of an in-order processor core. When the fetch or execute stage signals a boundary, it chooses between a pending synchronous exception and an external interrupt request. If one is accepted, it performs the whole entry sequence in one clock. The old status word, program counter and stack pointer go to the save registers. The event code is latched, the status word is switched to privileged, register-bank-1 and blocked state, and a handler address is produced. A one-cycle pulse then tells the fetch unit to redirect.

The handler address depends on the kind of event. Reset-class codes go to a fixed boot address. Translation-miss codes and other exceptions go to two different offsets from the vector base register. Interrupts go to a third offset. While the blocked bit of the status word is set, interrupts are ignored. Any exception other than the one allowed code is turned into a power-on reset.

The current interrupt mask level is driven back to the interrupt controller. That controller returns a request, a priority level and a vector code.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When an exception and an acceptable interrupt are both pending at a boundary, the exception is taken and INTEVT (`intevt_o`) keeps its value.
- R2: With status bit 28 (blocked) set, a pending exception whose code is not 0x1E0 is taken as code 0x000 with reset handling. Code 0x1E0 under the blocked bit is taken normally as a general exception.
- R3: With status bit 28 set, an interrupt request causes no entry and leaves every output unchanged.
- R4: An interrupt is accepted only when its level is strictly above status bits [7:4]. `imask_o` always equals status bits [7:4].
- R5: On entry, `ssr_o` takes the status word and `sgr_o` takes R15. `spc_o` takes the PC, or PC-2 when the delay-slot flag is set.
- R6: On entry, `sr_o` is the incoming status word with bits 30 (privileged), 29 (bank) and 28 (blocked) forced to 1.
- R7: An entry taken with the delay-slot flag set gives `spc_o` = PC-2 and pulses `ds_clear_o` for one cycle. An entry without the flag leaves `ds_clear_o` low.
- R8: Codes 0x000 and 0x020 load EXPEVT with the code, force `sr_o[7:4]` to 0xF and set the new PC to 0xA0000000.
- R9: Codes 0x040 and 0x060 set the new PC to VBR+0x400. Any other non-reset exception code sets it to VBR+0x100.
- R10: Code 0x160 saves `spc_o` as the value from R5 plus 2.
- R11: An accepted interrupt loads INTEVT with the vector, sets the new PC to VBR+0x600 and leaves EXPEVT unchanged.
- R12: All results appear on the clock edge that samples `boundary_i`. `entry_o` is high for exactly that cycle. Without `boundary_i`, no output changes. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction boundary; entry may occur on this cycle |
| exc_pending_i | input | 1 | A synchronous exception is pending |
| exc_code_i | input | 12 | Code of the pending exception |
| irq_req_i | input | 1 | Interrupt controller has a request |
| irq_level_i | input | 4 | Priority level of that request |
| irq_vector_i | input | 12 | Vector code of that request |
| sr_i | input | 32 | Current status word |
| pc_i | input | ADDR_W | PC of the instruction at the boundary |
| r15_i | input | 32 | Current stack pointer register |
| vbr_i | input | ADDR_W | Vector base register |
| in_delay_slot_i | input | 1 | Boundary instruction sits in a branch delay slot |
| imask_o | output | 4 | Current mask level sent to the interrupt controller |
| entry_o | output | 1 | One-cycle pulse: redirect fetch to `pc_o` |
| ds_clear_o | output | 1 | One-cycle pulse: clear delay-slot flags |
| ssr_o | output | 32 | Saved status word |
| spc_o | output | ADDR_W | Saved PC |
| sgr_o | output | 32 | Saved R15 |
| expevt_o | output | 12 | Latched exception code |
| intevt_o | output | 12 | Latched interrupt vector |
| sr_o | output | 32 | Status word after entry |
| pc_o | output | ADDR_W | Handler address |

## Verification
A wrong arbitration or class decision shows up in the cycle right after the boundary. It appears as a handler address off by one of the fixed offsets, or as an event register written when it should have held. Both are caught by the per-clock comparison on that same cycle. A wrong saved-PC adjustment for delay slots or the trap code appears only in `spc_o`, also on the first cycle after entry. The event mixes are chosen so that each adjustment is visible on its own and in combination. A wrongly accepted interrupt under the blocked bit or the mask shows as a spurious `entry_o` pulse with a changed `intevt_o`.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CODE_W    = 12;
  localparam int SR_W      = 32;
  localparam int SR_BL     = 28;
  localparam int SR_RB     = 29;
  localparam int SR_MD     = 30;
  localparam int IMASK_LSB = 4;
  localparam int IMASK_W   = 4;

  localparam logic [CODE_W-1:0] C_POWER_ON = 12'h000;
  localparam logic [CODE_W-1:0] C_MANUAL   = 12'h020;
  localparam logic [CODE_W-1:0] C_TLB_RD   = 12'h040;
  localparam logic [CODE_W-1:0] C_TLB_WR   = 12'h060;
  localparam logic [CODE_W-1:0] C_TRAP     = 12'h160;
  localparam logic [CODE_W-1:0] C_BL_SAFE  = 12'h1E0;

  typedef enum logic [2:0] {
    EV_NONE, EV_RESET, EV_TLB, EV_GEN, EV_TRAP, EV_IRQ
  } ev_kind_t;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  logic                boundary_i,
  input  logic                exc_pending_i,
  input  logic [CODE_W-1:0]   exc_code_i,
  input  logic                irq_req_i,
  input  logic [IMASK_W-1:0]  irq_level_i,
  input  logic                blocked_i,
  input  logic [IMASK_W-1:0]  imask_i,
  output logic                take_o,
  output ev_kind_t            kind_o,
  output logic [CODE_W-1:0]   code_o
);
  logic irq_ok;
  logic [CODE_W-1:0] eff_code;

  always_comb begin
    eff_code = (blocked_i && exc_code_i != C_BL_SAFE) ? C_POWER_ON : exc_code_i;
    irq_ok   = irq_req_i && !blocked_i && (irq_level_i > imask_i);
  end

  always_comb begin
    take_o = 1'b0;
    kind_o = EV_NONE;
    code_o = eff_code;
    if (boundary_i) begin
      if (exc_pending_i) begin
        take_o = 1'b1;
        if (eff_code == C_POWER_ON || eff_code == C_MANUAL)
          kind_o = EV_RESET;
        else if (eff_code == C_TLB_RD || eff_code == C_TLB_WR)
          kind_o = EV_TLB;
        else if (eff_code == C_TRAP)
          kind_o = EV_TRAP;
        else
          kind_o = EV_GEN;
      end else if (irq_ok) begin
        take_o = 1'b1;
        kind_o = EV_IRQ;
      end
    end
  end
endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PC_STEP    = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = ADDR_W'(32'hA000_0000),
  parameter int OFS_GEN    = 'h100,
  parameter int OFS_TLB    = 'h400,
  parameter int OFS_IRQ    = 'h600
) (
  input  ev_kind_t            kind_i,
  input  logic [ADDR_W-1:0]   vbr_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic                in_ds_i,
  output logic [ADDR_W-1:0]   new_pc_o,
  output logic [ADDR_W-1:0]   spc_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);
  logic [ADDR_W-1:0] base_spc;

  always_comb begin
    base_spc = in_ds_i ? (pc_i - STEP) : pc_i;
    spc_o    = (kind_i == EV_TRAP) ? (base_spc + STEP) : base_spc;
  end

  always_comb begin
    unique case (kind_i)
      EV_RESET: new_pc_o = RESET_PC;
      EV_TLB:   new_pc_o = vbr_i + ADDR_W'(OFS_TLB);
      EV_IRQ:   new_pc_o = vbr_i + ADDR_W'(OFS_IRQ);
      EV_GEN,
      EV_TRAP:  new_pc_o = vbr_i + ADDR_W'(OFS_GEN);
      default:  new_pc_o = pc_i;
    endcase
  end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                take_i,
  input  ev_kind_t            kind_i,
  input  logic [CODE_W-1:0]   code_i,
  input  logic [CODE_W-1:0]   vector_i,
  input  logic [SR_W-1:0]     sr_i,
  input  logic [31:0]         r15_i,
  input  logic                in_ds_i,
  input  logic [ADDR_W-1:0]   new_pc_i,
  input  logic [ADDR_W-1:0]   spc_i,
  output logic                entry_o,
  output logic                ds_clear_o,
  output logic [SR_W-1:0]     ssr_o,
  output logic [ADDR_W-1:0]   spc_o,
  output logic [31:0]         sgr_o,
  output logic [CODE_W-1:0]   expevt_o,
  output logic [CODE_W-1:0]   intevt_o,
  output logic [SR_W-1:0]     sr_o,
  output logic [ADDR_W-1:0]   pc_o
);
  logic [SR_W-1:0] sr_next;

  always_comb begin
    sr_next = sr_i;
    sr_next[SR_BL] = 1'b1;
    sr_next[SR_RB] = 1'b1;
    sr_next[SR_MD] = 1'b1;
    if (kind_i == EV_RESET)
      sr_next[IMASK_LSB +: IMASK_W] = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_o    <= 1'b0;
      ds_clear_o <= 1'b0;
      ssr_o      <= '0;
      spc_o      <= '0;
      sgr_o      <= '0;
      expevt_o   <= '0;
      intevt_o   <= '0;
      sr_o       <= '0;
      pc_o       <= '0;
    end else begin
      entry_o    <= take_i;
      ds_clear_o <= take_i && in_ds_i;
      if (take_i) begin
        ssr_o <= sr_i;
        spc_o <= spc_i;
        sgr_o <= r15_i;
        sr_o  <= sr_next;
        pc_o  <= new_pc_i;
        if (kind_i == EV_IRQ) intevt_o <= vector_i;
        else                  expevt_o <= code_i;
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               boundary_i,
  input  logic               exc_pending_i,
  input  logic [11:0]        exc_code_i,
  input  logic               irq_req_i,
  input  logic [3:0]         irq_level_i,
  input  logic [11:0]        irq_vector_i,
  input  logic [31:0]        sr_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [31:0]        r15_i,
  input  logic [ADDR_W-1:0]  vbr_i,
  input  logic               in_delay_slot_i,
  output logic [3:0]         imask_o,
  output logic               entry_o,
  output logic               ds_clear_o,
  output logic [31:0]        ssr_o,
  output logic [ADDR_W-1:0]  spc_o,
  output logic [31:0]        sgr_o,
  output logic [11:0]        expevt_o,
  output logic [11:0]        intevt_o,
  output logic [31:0]        sr_o,
  output logic [ADDR_W-1:0]  pc_o
);
  logic              take;
  ev_kind_t          kind;
  logic [CODE_W-1:0] code_eff;
  logic [ADDR_W-1:0] new_pc;
  logic [ADDR_W-1:0] spc_val;

  assign imask_o = sr_i[IMASK_LSB +: IMASK_W];

  exc_arbiter u_arb (
    .boundary_i    (boundary_i),
    .exc_pending_i (exc_pending_i),
    .exc_code_i    (exc_code_i),
    .irq_req_i     (irq_req_i),
    .irq_level_i   (irq_level_i),
    .blocked_i     (sr_i[SR_BL]),
    .imask_i       (sr_i[IMASK_LSB +: IMASK_W]),
    .take_o        (take),
    .kind_o        (kind),
    .code_o        (code_eff)
  );

  exc_target #(.ADDR_W(ADDR_W)) u_tgt (
    .kind_i   (kind),
    .vbr_i    (vbr_i),
    .pc_i     (pc_i),
    .in_ds_i  (in_delay_slot_i),
    .new_pc_o (new_pc),
    .spc_o    (spc_val)
  );

  exc_state_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .take_i     (take),
    .kind_i     (kind),
    .code_i     (code_eff),
    .vector_i   (irq_vector_i),
    .sr_i       (sr_i),
    .r15_i      (r15_i),
    .in_ds_i    (in_delay_slot_i),
    .new_pc_i   (new_pc),
    .spc_i      (spc_val),
    .entry_o    (entry_o),
    .ds_clear_o (ds_clear_o),
    .ssr_o      (ssr_o),
    .spc_o      (spc_o),
    .sgr_o      (sgr_o),
    .expevt_o   (expevt_o),
    .intevt_o   (intevt_o),
    .sr_o       (sr_o),
    .pc_o       (pc_o)
  );

  AST_EXC_BEATS_IRQ: assert property (@(posedge clk) disable iff (rst)
    boundary_i && exc_pending_i |=> entry_o && $stable(intevt_o)); // R1
  AST_BL_TO_RESET: assert property (@(posedge clk) disable iff (rst)
    boundary_i && exc_pending_i && sr_i[SR_BL] && exc_code_i != C_BL_SAFE
    |=> expevt_o == C_POWER_ON && pc_o == ADDR_W'(32'hA000_0000)); // R2
  AST_BL_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    boundary_i && !exc_pending_i && sr_i[SR_BL] |=> !entry_o); // R3
  AST_ENTRY_SR_BITS: assert property (@(posedge clk) disable iff (rst)
    entry_o |-> sr_o[SR_MD] && sr_o[SR_RB] && sr_o[SR_BL]); // R6
  AST_DSCLR_WITH_ENTRY: assert property (@(posedge clk) disable iff (rst)
    ds_clear_o |-> entry_o); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !boundary_i |=> !entry_o && $stable(pc_o) && $stable(expevt_o)); // R12
endmodule

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boundary_i = 0, exc_pending_i = 0, irq_req_i = 0, in_delay_slot_i = 0;
  logic [11:0] exc_code_i = 0, irq_vector_i = 0;
  logic [3:0]  irq_level_i = 0;
  logic [31:0] sr_i = 0, pc_i = 0, r15_i = 0, vbr_i = 0;
  logic [3:0]  imask_o;
  logic        entry_o, ds_clear_o;
  logic [31:0] ssr_o, spc_o, sgr_o, sr_o, pc_o;
  logic [11:0] expevt_o, intevt_o;

  int compared = 0, mismatched = 0, cycles = 0;
  string cur_req = "R12";

  logic        e_entry, e_dsclr;
  logic [31:0] e_ssr, e_spc, e_sgr, e_sr, e_pc;
  logic [11:0] e_exp, e_int;

  always #4 clk = ~clk;

  exc_entry_ctrl u_dut (.*);

  always @(posedge clk) begin
    if (rst) begin
      e_entry = 0; e_dsclr = 0; e_ssr = 0; e_spc = 0; e_sgr = 0;
      e_sr = 0; e_pc = 0; e_exp = 0; e_int = 0;
    end else begin
      logic bl, do_exc, do_irq;
      logic [11:0] c;
      bl = sr_i[28];
      do_exc = boundary_i && exc_pending_i;
      do_irq = boundary_i && !exc_pending_i && irq_req_i && !bl && (irq_level_i > sr_i[7:4]);
      e_entry = do_exc || do_irq;
      e_dsclr = e_entry && in_delay_slot_i;
      if (e_entry) begin
        e_ssr = sr_i; e_sgr = r15_i;
        e_spc = in_delay_slot_i ? pc_i - 2 : pc_i;
        e_sr = sr_i | 32'h7000_0000;
        if (do_irq) begin
          e_int = irq_vector_i; e_pc = vbr_i + 32'h600;
        end else begin
          c = (bl && exc_code_i != 12'h1E0) ? 12'h000 : exc_code_i;
          e_exp = c;
          if (c == 12'h000 || c == 12'h020) begin
            e_sr[7:4] = 4'hF; e_pc = 32'hA000_0000;
          end else if (c == 12'h040 || c == 12'h060) e_pc = vbr_i + 32'h400;
          else e_pc = vbr_i + 32'h100;
          if (c == 12'h160) e_spc = e_spc + 2;
        end
      end
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("entry", 32'(entry_o), 32'(e_entry));
      chk("ds_clear", 32'(ds_clear_o), 32'(e_dsclr));
      chk("ssr", ssr_o, e_ssr);
      chk("spc", spc_o, e_spc);
      chk("sgr", sgr_o, e_sgr);
      chk("sr", sr_o, e_sr);
      chk("pc", pc_o, e_pc);
      chk("expevt", 32'(expevt_o), 32'(e_exp));
      chk("intevt", 32'(intevt_o), 32'(e_int));
      chk("imask", 32'(imask_o), 32'(sr_i[7:4]));
    end
    if (cycles > 5000) begin
      mismatched++;
      $display("FAIL watchdog actual %0d expected <5000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic ev(string req, logic exc, logic [11:0] code, logic irq, logic [3:0] lvl,
                    logic [11:0] vec, logic [31:0] sr, logic ds, logic bnd);
    @(negedge clk);
    cur_req = req;
    exc_pending_i = exc; exc_code_i = code; irq_req_i = irq; irq_level_i = lvl;
    irq_vector_i = vec; sr_i = sr; in_delay_slot_i = ds; boundary_i = bnd;
    pc_i = pc_i + 32'h10; r15_i = r15_i + 32'h44; vbr_i = vbr_i + 32'h1000;
    @(negedge clk);
    boundary_i = 0;
  endtask

  initial begin
    pc_i = 32'h0C00_1000; r15_i = 32'h8C00_FF00; vbr_i = 32'h8000_0000;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R12";
    chk("reset pc", pc_o, 32'h0);
    chk("reset entry", 32'(entry_o), 32'h0);
    ev("R12", 1, 12'h0A0, 0, 0, 0, 32'h0000_0030, 0, 0);
    chk("idle entry", 32'(entry_o), 0);
    ev("R9", 1, 12'h0A0, 0, 0, 0, 32'h0000_0030, 0, 1);
    chk("general pc", pc_o, vbr_i + 32'h100);
    ev("R9", 1, 12'h040, 0, 0, 0, 32'h0000_0001, 0, 1);
    chk("tlb pc", pc_o, vbr_i + 32'h400);
    ev("R9", 1, 12'h060, 0, 0, 0, 32'h0000_0000, 0, 1);
    ev("R8", 1, 12'h020, 0, 0, 0, 32'h0000_0020, 0, 1);
    chk("reset imask", 32'(sr_o[7:4]), 32'hF);
    ev("R8", 1, 12'h000, 0, 0, 0, 32'h0000_0000, 0, 1);
    ev("R10", 1, 12'h160, 0, 0, 0, 32'h0000_0010, 0, 1);
    chk("trap spc", spc_o, pc_i + 2);
    ev("R7", 1, 12'h0E0, 0, 0, 0, 32'h0000_0010, 1, 1);
    chk("ds spc", spc_o, pc_i - 2);
    chk("ds pulse", 32'(ds_clear_o), 1);
    ev("R10", 1, 12'h160, 0, 0, 0, 32'h0000_0010, 1, 1);
    ev("R11", 0, 0, 1, 5, 12'h3C0, 32'h0000_0030, 0, 1);
    chk("irq pc", pc_o, vbr_i + 32'h600);
    ev("R4", 0, 0, 1, 3, 12'h320, 32'h0000_0030, 0, 1);
    chk("irq at mask", 32'(entry_o), 0);
    ev("R4", 0, 0, 1, 4, 12'h340, 32'h0000_0030, 0, 1);
    ev("R1", 1, 12'h0C0, 1, 15, 12'h200, 32'h0000_0000, 0, 1);
    chk("prio intevt", 32'(intevt_o), 32'h340);
    ev("R2", 1, 12'h0A0, 0, 0, 0, 32'h1000_0050, 0, 1);
    chk("bl reset pc", pc_o, 32'hA000_0000);
    ev("R2", 1, 12'h1E0, 0, 0, 0, 32'h1000_0050, 0, 1);
    chk("bl safe pc", pc_o, vbr_i + 32'h100);
    ev("R3", 0, 0, 1, 15, 12'h600, 32'h1000_0000, 0, 1);
    chk("bl irq", 32'(entry_o), 0);
    ev("R5", 1, 12'h100, 0, 0, 0, 32'h4000_00F3, 0, 1);
    chk("sgr", sgr_o, r15_i);
    ev("R6", 1, 12'h180, 0, 0, 0, 32'h0000_0301, 0, 1);
    chk("sr out", sr_o, 32'h7000_0301);
    ev("R12", 0, 0, 1, 9, 12'h5A0, 32'h0000_0000, 0, 0);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule